// File: doc/BRIEF.md
# 10BASE-T Link Integrity Monitor

This block sits beside a 10BASE-T receive path and decides whether the local transmitter may put data on the wire. The receive front end gives it two one-cycle strobes: one for each valid link pulse and one for received packet activity. A link-pulse strobe seen while the link is down brings the link up. After that, any pulse or packet strobe keeps it up. If neither kind of strobe arrives for a programmable number of clock cycles, the link is declared failed. When auto-negotiation is enabled, the block then issues a single-cycle request to restart it.

A test-off input lets the transmitter send whatever the link state. While it is set, the link-good flag still follows pulse activity but no longer gates transmission. The block does not detect pulses, make outgoing link pulses or run auto-negotiation. Outgoing link pulses are sent all the time by other logic, whatever this monitor decides. The loss window is the parameter `LOSS_CYCLES`. Its default of 30,000,000 cycles is 150 ms at 200 MHz.

Top module: `link_guard`

## Requirements
- R1: After reset, `link_ok`, `tx_allow` and `an_restart` are all 0.
- R2: While `link_ok` is 0, a `pulse_stb` sampled high at a rising edge sets `link_ok` to 1 from that edge on.
- R3: While `link_ok` is 0, `pkt_stb` alone never sets `link_ok`.
- R4: While `link_ok` is 1, every `pulse_stb` or `pkt_stb` restarts the idle count, so the link stays up as long as no run of `LOSS_CYCLES` consecutive strobe-free cycles occurs.
- R5: `link_ok` falls at the edge that samples the `LOSS_CYCLES`-th consecutive cycle with neither strobe after the last strobe.
- R6: When `an_enable` is 1 at that edge, `an_restart` is 1 for exactly that one cycle, coinciding with the fall of `link_ok`.
- R7: When `an_enable` is 0 at that edge, `an_restart` stays 0. It is never 1 except on a good-to-fail transition.
- R8: When `test_off` is sampled high at an edge, `tx_allow` is 1 from that edge on, whatever the link state. `link_ok` keeps following R2 to R5.
- R9: When `test_off` is sampled low at an edge, `tx_allow` equals `link_ok` from that edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_stb | input | 1 | One-cycle strobe per valid received link pulse |
| pkt_stb | input | 1 | One-cycle strobe for received packet activity |
| test_off | input | 1 | 1 disables the integrity test so transmit is always allowed |
| an_enable | input | 1 | 1 when auto-negotiation is enabled |
| link_ok | output | 1 | Link-good flag |
| tx_allow | output | 1 | Transmit permission |
| an_restart | output | 1 | One-cycle request to restart auto-negotiation on link failure |

## Verification
Every output is a register, so each result appears one rising edge after the inputs that cause it. A pulse raises `link_ok` at its own sampling edge. Failure and the restart pulse land on the `LOSS_CYCLES`-th idle edge. A change of `test_off` reaches `tx_allow` at the edge that samples it. The bench drives inputs just after a rising edge and reads the outputs one nanosecond after the next rising edge. Before each read it advances a cycle-by-cycle arithmetic model of the idle count. Idle gaps from one cycle to beyond the window are swept with each value of `an_enable` and `test_off`.

// File: rtl/lg_pkg.sv
package lg_pkg;
    typedef struct packed {
        logic link;
        logic tx;
        logic restart;
    } lg_state_t;

    localparam lg_state_t LG_RESET = '{link: 1'b0, tx: 1'b0, restart: 1'b0};
endpackage

// File: rtl/lg_idle_timer.sv
module lg_idle_timer #(
    parameter int LOSS_CYCLES = 30_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic activity,
    output logic expire
);
    localparam int IDLE_W = (LOSS_CYCLES > 2) ? $clog2(LOSS_CYCLES) : 1;
    localparam logic [IDLE_W-1:0] LAST = IDLE_W'(LOSS_CYCLES - 1);

    logic [IDLE_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (activity) begin
            count_d = '0;
        end else if (count_q != LAST) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    // expiry: this cycle is the LOSS_CYCLES-th without a strobe
    assign expire = !activity && (count_q == LAST);

    // R4: a strobe always restarts the idle count
    assert_strobe_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> (count_q == '0));

    // R5: the count saturates at the window end and never passes it
    assert_count_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= LAST);
endmodule

// File: rtl/lg_link_state.sv
module lg_link_state
    import lg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_stb,
    input  logic expire,
    input  logic test_off,
    input  logic an_enable,
    output logic link_ok,
    output logic tx_allow,
    output logic an_restart
);
    lg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.restart = 1'b0;
        if (!st_q.link) begin
            st_d.link = pulse_stb;
        end else if (expire) begin
            st_d.link    = 1'b0;
            st_d.restart = an_enable;
        end
        st_d.tx = test_off | st_d.link;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= LG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign link_ok    = st_q.link;
    assign tx_allow   = st_q.tx;
    assign an_restart = st_q.restart;

    // R3: without a pulse a down link stays down
    assert_no_rise_without_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_ok && !pulse_stb) |=> !link_ok);

    // R6: the restart request lasts a single cycle
    assert_restart_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart |=> !an_restart);

    // R7: restart only on a fall of the link with auto-negotiation enabled
    assert_restart_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_ok || !an_enable) |=> !an_restart);

    // R8: test disabled forces transmit on
    assert_forced_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        test_off |=> tx_allow);

    // R9: test enabled makes transmit follow the link
    assert_tx_follows_link_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !test_off |=> (tx_allow == link_ok));
endmodule

// File: rtl/link_guard.sv
module link_guard #(
    parameter int LOSS_CYCLES = 30_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_stb,
    input  logic pkt_stb,
    input  logic test_off,
    input  logic an_enable,
    output logic link_ok,
    output logic tx_allow,
    output logic an_restart
);
    logic activity;
    logic expire;

    assign activity = pulse_stb | pkt_stb;

    lg_idle_timer #(
        .LOSS_CYCLES(LOSS_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .activity (activity),
        .expire   (expire)
    );

    lg_link_state u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_stb  (pulse_stb),
        .expire     (expire),
        .test_off   (test_off),
        .an_enable  (an_enable),
        .link_ok    (link_ok),
        .tx_allow   (tx_allow),
        .an_restart (an_restart)
    );

    // R2: a pulse always leaves the link up
    assert_pulse_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_stb |=> link_ok);
endmodule

// File: tb/link_guard_tb.sv
module link_guard_tb;
    localparam int L = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pulse_stb = 1'b0;
    logic pkt_stb = 1'b0;
    logic test_off = 1'b0;
    logic an_enable = 1'b0;
    logic link_ok, tx_allow, an_restart;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit m_link = 1'b0;
    bit m_tx = 1'b0;
    bit m_rs = 1'b0;
    int m_idle = 0;

    always #2.5 clk = ~clk;

    link_guard #(.LOSS_CYCLES(L)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_stb  (pulse_stb),
        .pkt_stb    (pkt_stb),
        .test_off   (test_off),
        .an_enable  (an_enable),
        .link_ok    (link_ok),
        .tx_allow   (tx_allow),
        .an_restart (an_restart)
    );

    task automatic check(input string req, input string what, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "link_ok", link_ok, m_link);
        check(req, "tx_allow", tx_allow, m_tx);
        check(req, "an_restart", an_restart, m_rs);
    endtask

    // one clock: apply strobes, advance the model at the edge, check 1 ns later
    task automatic cyc(input bit p, input bit k, input string req);
        bit act, nl, rs;
        pulse_stb = p;
        pkt_stb = k;
        @(posedge clk);
        act = p | k;
        rs = 1'b0;
        if (!m_link) begin
            nl = p;
        end else if (!act && m_idle == L - 1) begin
            nl = 1'b0;
            rs = an_enable;
        end else begin
            nl = 1'b1;
        end
        if (act) m_idle = 0;
        else if (m_idle < L - 1) m_idle++;
        m_link = nl;
        m_rs = rs;
        m_tx = test_off | nl;
        #1;
        check_all(req);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "link_ok", link_ok, 1'b0);
        check("R1", "tx_allow", tx_allow, 1'b0);
        check("R1", "an_restart", an_restart, 1'b0);
        rst_n = 1'b1;

        // R3: packets alone do not bring the link up
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, "R3");
        cyc(1'b0, 1'b0, "R3");

        // R2: a pulse brings it up at once
        cyc(1'b1, 1'b0, "R2");
        check("R2", "link_ok up", link_ok, 1'b1);

        // R4: packet traffic with gaps just under the window keeps it up
        for (int r = 0; r < 4; r++) begin
            for (int g = 0; g < L - 1; g++) cyc(1'b0, 1'b0, "R4");
            cyc(1'b0, 1'b1, "R4");
            check("R4", "link held by packets", link_ok, 1'b1);
        end
        for (int r = 0; r < 3; r++) begin
            for (int g = 0; g < L - 1; g++) cyc(1'b0, 1'b0, "R4");
            cyc(1'b1, 1'b0, "R4");
        end

        // R5/R6/R7/R8/R9: sweep idle gaps for every mode combination
        for (int mode = 0; mode < 4; mode++) begin
            an_enable = mode[0];
            test_off = mode[1];
            for (int gap = 1; gap <= L + 2; gap++) begin
                cyc(1'b1, 1'b0, mode[1] ? "R8" : "R9");
                for (int j = 1; j <= gap; j++) begin
                    cyc(1'b0, 1'b0, (j == L) ? (mode[0] ? "R6" : "R7") : "R5");
                    check("R5", "link vs idle count", link_ok, (j < L));
                    check(mode[0] ? "R6" : "R7", "restart at fall",
                          an_restart, (j == L) && mode[0]);
                end
            end
            // stay down a while: no repeated restart, packets do not revive
            for (int j = 0; j < 3; j++) cyc(1'b0, 1'b1, "R7");
            check("R8", "tx forced while down", tx_allow, mode[1]);
        end

        // R8/R9: toggling test_off while down takes effect at the next edge
        test_off = 1'b1;
        cyc(1'b0, 1'b0, "R8");
        check("R8", "forced on", tx_allow, 1'b1);
        test_off = 1'b0;
        cyc(1'b0, 1'b0, "R9");
        check("R9", "gated off", tx_allow, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule